// File: doc/BRIEF.md
# SMBus Host Controller Register Interface

This block is the software-facing register file of an SMBus host controller. A host bus makes byte-wide reads and writes at eight offsets. Through them software sets a target address with a direction bit, a command code, two data bytes and a protocol code. It then writes the control register with the start bit set. The block passes the transaction to a bit-level SMBus master over a request/response handshake. For reads it places the returned bytes in the data registers, and it reports busy, done and device-error in a status register.

A 32-entry byte buffer carries block payloads. The host reaches it through a single data port whose index advances on every access and wraps back to zero. The master reaches the same buffer through its own indexed port. The protocol code sits in control bits 4:2 and the direction in bit 0 of the slave-address register. The master uses both to choose between quick command, send/receive byte, write/read byte data, write/read word data and block write/read.

Top module: `smb_host_regs`

## Requirements
- R1: After reset every register reads 0x00, the block index is 0 and mst_req is low.
- R2: Offsets are status 0, control 2, command 3, slave address 4, data0 5, data1 6, block port 7; offset 1 reads 0. Control reads return only its bits 4:0. Writing control with bit 6 set while idle starts a transaction: from the next cycle mst_req is high, status bit 0 (busy) is set, mst_proto carries control bits 4:2, mst_rd carries slave-address bit 0 (1 = read) and mst_taddr carries bits 7:1.
- R3: Protocol codes are 0 quick, 1 send/receive byte, 2 write/read byte data, 3 write/read word data, 5 block. A start with code 4, 6 or 7 raises no request and sets status bit 2 (error).
- R4: A response without NACK clears busy and sets status bit 1 (done). A response with NACK clears busy and sets status bit 2 instead of done, leaving the data registers unchanged.
- R5: On a successful read, byte and byte-data protocols load data0, word loads data0 with the low byte and data1 with the high byte, and block loads data0 with the returned count. Writes and quick commands leave data0 and data1 unchanged.
- R6: Each access to offset 7 reads or writes the buffer entry at the current index and then increments the index, wrapping from 31 to 0.
- R7: Starting a transaction resets the block index to 0.
- R8: mst_buf_rdata always shows the entry at mst_buf_idx. mst_buf_we stores mst_buf_wdata at mst_buf_idx only while busy.
- R9: Writing 1 to status bit 1 or bit 2 clears that bit, writing 0 leaves it, and the busy bit cannot be written.
- R10: While busy, writes to every register except status are ignored, including another start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (advances block index at offset 7) |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr |
| mst_req | output | 1 | Transaction request, high while busy |
| mst_proto | output | 3 | Protocol code |
| mst_rd | output | 1 | Direction, 1 = read |
| mst_taddr | output | 7 | 7-bit target address |
| mst_cmd | output | 8 | Command code |
| mst_d0 | output | 8 | Data0 (low byte or block count) |
| mst_d1 | output | 8 | Data1 (high byte) |
| mst_buf_idx | input | 5 | Master buffer index |
| mst_buf_rdata | output | 8 | Buffer entry at mst_buf_idx |
| mst_buf_we | input | 1 | Master buffer write enable |
| mst_buf_wdata | input | 8 | Master buffer write data |
| mst_rsp | input | 1 | One-cycle completion pulse |
| mst_nack | input | 1 | Completion was a NACK |
| mst_rsp_d0 | input | 8 | Returned low byte or block count |
| mst_rsp_d1 | input | 8 | Returned high byte |

## Verification
The bench walks the block port through all 32 entries and one more read. If the wrap were off by one, entry 0 would not come back on the 33rd read. A block write started with a non-zero index must present entry 0 to the master and then read it back first; a design that kept the old index would skew the payload. Register writes and a second start are attempted in mid-transaction, and a design without the busy gate would change the command or protocol under the master. NACK, unsupported codes and partial write-1-to-clear patterns are checked, so done set on error, a request for code 4, or a status bit cleared by a written 0 would each show up in the status byte.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

    localparam int BYTE_W    = 8;
    localparam int OFS_W     = 3;
    localparam int CTL_W     = 5;
    localparam int PROTO_LSB = 2;
    localparam int PROTO_W   = 3;

    localparam logic [OFS_W-1:0] OFS_STS = 3'd0;
    localparam logic [OFS_W-1:0] OFS_CTL = 3'd2;
    localparam logic [OFS_W-1:0] OFS_CMD = 3'd3;
    localparam logic [OFS_W-1:0] OFS_ADR = 3'd4;
    localparam logic [OFS_W-1:0] OFS_D0  = 3'd5;
    localparam logic [OFS_W-1:0] OFS_D1  = 3'd6;
    localparam logic [OFS_W-1:0] OFS_BLK = 3'd7;

    localparam int STS_BUSY  = 0;
    localparam int STS_DONE  = 1;
    localparam int STS_ERR   = 2;
    localparam int CTL_START = 6;

    typedef enum logic [PROTO_W-1:0] {
        PR_QUICK = 3'd0,
        PR_BYTE  = 3'd1,
        PR_BDATA = 3'd2,
        PR_WORD  = 3'd3,
        PR_BLOCK = 3'd5
    } proto_e;

    typedef enum logic {
        XS_IDLE = 1'b0,
        XS_WAIT = 1'b1
    } xs_e;

    typedef struct packed {
        logic [CTL_W-1:0]  ctl;
        logic [BYTE_W-1:0] cmd;
        logic [BYTE_W-1:0] sadr;
        logic [BYTE_W-1:0] d0;
        logic [BYTE_W-1:0] d1;
        logic              done;
        logic              err;
    } regs_t;

    function automatic logic proto_ok(input logic [PROTO_W-1:0] p);
        return (p == PR_QUICK) || (p == PR_BYTE) || (p == PR_BDATA) ||
               (p == PR_WORD)  || (p == PR_BLOCK);
    endfunction

endpackage

// File: rtl/smb_blk_buf.sv
module smb_blk_buf #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_clr,
    input  logic              host_we,
    input  logic              host_adv,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic [IDX_W-1:0]  idx,
    input  logic [IDX_W-1:0]  mst_idx,
    input  logic              mst_we,
    input  logic [DATA_W-1:0] mst_wdata,
    output logic [DATA_W-1:0] mst_rdata
);

    typedef struct packed {
        logic [IDX_W-1:0]             idx;
        logic [DEPTH-1:0][DATA_W-1:0] mem;
    } buf_t;

    buf_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (mst_we) begin
            b_d.mem[mst_idx] = mst_wdata;
        end
        if (host_we) begin
            b_d.mem[b_q.idx] = host_wdata;
        end
        if (idx_clr) begin
            b_d.idx = '0;
        end else if (host_adv) begin
            b_d.idx = (b_q.idx == IDX_W'(DEPTH - 1)) ? '0 : b_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign host_rdata = b_q.mem[b_q.idx];
    assign mst_rdata  = b_q.mem[mst_idx];
    assign idx        = b_q.idx;

endmodule

// File: rtl/smb_xfer_ctl.sv
module smb_xfer_ctl
    import smb_host_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  logic [PROTO_W-1:0] launch_proto,
    input  logic               rsp,
    input  logic               nack,
    output logic               busy,
    output logic               fin_ok,
    output logic               fin_err
);

    typedef struct packed {
        xs_e st;
    } xs_t;

    xs_t s_d, s_q;
    logic bad_start;

    always_comb begin
        s_d       = s_q;
        fin_ok    = 1'b0;
        fin_err   = 1'b0;
        bad_start = 1'b0;
        unique case (s_q.st)
            XS_IDLE: begin
                if (launch) begin
                    if (proto_ok(launch_proto)) begin
                        s_d.st = XS_WAIT;
                    end else begin
                        bad_start = 1'b1;
                    end
                end
            end
            XS_WAIT: begin
                if (rsp) begin
                    s_d.st  = XS_IDLE;
                    fin_ok  = !nack;
                    fin_err = nack;
                end
            end
            default: s_d.st = XS_IDLE;
        endcase
        fin_err = fin_err | bad_start;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: XS_IDLE};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.st == XS_WAIT);

endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smb_host_pkg::*;
#(
    parameter int BUF_DEPTH = 32,
    localparam int IDX_W    = $clog2(BUF_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [OFS_W-1:0]   host_addr,
    input  logic [BYTE_W-1:0]  host_wdata,
    output logic [BYTE_W-1:0]  host_rdata,
    output logic               mst_req,
    output logic [PROTO_W-1:0] mst_proto,
    output logic               mst_rd,
    output logic [6:0]         mst_taddr,
    output logic [BYTE_W-1:0]  mst_cmd,
    output logic [BYTE_W-1:0]  mst_d0,
    output logic [BYTE_W-1:0]  mst_d1,
    input  logic [IDX_W-1:0]   mst_buf_idx,
    output logic [BYTE_W-1:0]  mst_buf_rdata,
    input  logic               mst_buf_we,
    input  logic [BYTE_W-1:0]  mst_buf_wdata,
    input  logic               mst_rsp,
    input  logic               mst_nack,
    input  logic [BYTE_W-1:0]  mst_rsp_d0,
    input  logic [BYTE_W-1:0]  mst_rsp_d1
);

    regs_t r_d, r_q;

    logic              busy;
    logic              fin_ok;
    logic              fin_err;
    logic              wr_ok;
    logic              launch;
    logic              blk_we;
    logic              blk_adv;
    logic [BYTE_W-1:0] blk_rdata;
    logic [IDX_W-1:0]  blk_idx;
    logic              sts_done;
    logic              sts_err;

    assign wr_ok   = host_wr && !busy;
    assign launch  = wr_ok && (host_addr == OFS_CTL) && host_wdata[CTL_START];
    assign blk_we  = wr_ok && (host_addr == OFS_BLK);
    assign blk_adv = (host_rd || wr_ok) && (host_addr == OFS_BLK);

    smb_xfer_ctl u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch       (launch),
        .launch_proto (host_wdata[PROTO_LSB +: PROTO_W]),
        .rsp          (mst_rsp),
        .nack         (mst_nack),
        .busy         (busy),
        .fin_ok       (fin_ok),
        .fin_err      (fin_err)
    );

    smb_blk_buf #(
        .DEPTH  (BUF_DEPTH),
        .DATA_W (BYTE_W)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_clr    (launch),
        .host_we    (blk_we),
        .host_adv   (blk_adv),
        .host_wdata (host_wdata),
        .host_rdata (blk_rdata),
        .idx        (blk_idx),
        .mst_idx    (mst_buf_idx),
        .mst_we     (mst_buf_we && busy),
        .mst_wdata  (mst_buf_wdata),
        .mst_rdata  (mst_buf_rdata)
    );

    always_comb begin
        r_d = r_q;
        if (wr_ok) begin
            unique case (host_addr)
                OFS_CTL: r_d.ctl  = host_wdata[CTL_W-1:0];
                OFS_CMD: r_d.cmd  = host_wdata;
                OFS_ADR: r_d.sadr = host_wdata;
                OFS_D0:  r_d.d0   = host_wdata;
                OFS_D1:  r_d.d1   = host_wdata;
                default: ;
            endcase
        end
        if (host_wr && (host_addr == OFS_STS)) begin
            if (host_wdata[STS_DONE]) r_d.done = 1'b0;
            if (host_wdata[STS_ERR])  r_d.err  = 1'b0;
        end
        if (fin_ok) begin
            r_d.done = 1'b1;
            if (r_q.sadr[0]) begin
                unique case (r_q.ctl[PROTO_LSB +: PROTO_W])
                    PR_BYTE, PR_BDATA, PR_BLOCK: r_d.d0 = mst_rsp_d0;
                    PR_WORD: begin
                        r_d.d0 = mst_rsp_d0;
                        r_d.d1 = mst_rsp_d1;
                    end
                    default: ;
                endcase
            end
        end
        if (fin_err) begin
            r_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (host_addr)
            OFS_STS: host_rdata = {5'b0, r_q.err, r_q.done, busy};
            OFS_CTL: host_rdata = {{(BYTE_W-CTL_W){1'b0}}, r_q.ctl};
            OFS_CMD: host_rdata = r_q.cmd;
            OFS_ADR: host_rdata = r_q.sadr;
            OFS_D0:  host_rdata = r_q.d0;
            OFS_D1:  host_rdata = r_q.d1;
            OFS_BLK: host_rdata = blk_rdata;
            default: host_rdata = '0;
        endcase
    end

    assign mst_req   = busy;
    assign mst_proto = r_q.ctl[PROTO_LSB +: PROTO_W];
    assign mst_rd    = r_q.sadr[0];
    assign mst_taddr = r_q.sadr[7:1];
    assign mst_cmd   = r_q.cmd;
    assign mst_d0    = r_q.d0;
    assign mst_d1    = r_q.d1;
    assign sts_done  = r_q.done;
    assign sts_err   = r_q.err;

endmodule

// File: rtl/smb_host_chk.sv
module smb_host_chk
    import smb_host_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_wr,
    input logic               host_rd,
    input logic [OFS_W-1:0]   host_addr,
    input logic [BYTE_W-1:0]  host_wdata,
    input logic               mst_req,
    input logic               mst_rsp,
    input logic               mst_nack,
    input logic [PROTO_W-1:0] mst_proto,
    input logic               mst_rd,
    input logic [6:0]         mst_taddr,
    input logic [BYTE_W-1:0]  mst_cmd,
    input logic               sts_done,
    input logic               sts_err,
    input logic [IDX_W-1:0]   blk_idx
);

    a_r2_req_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mst_req) |-> $past(host_wr && (host_addr == OFS_CTL) && host_wdata[CTL_START]));

    a_r3_req_proto_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mst_req |-> proto_ok(mst_proto));

    a_r4_done_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_req && mst_rsp && !mst_nack) |=> (sts_done && !mst_req));

    a_r4_err_on_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_req && mst_rsp && mst_nack) |=> (sts_err && !mst_req));

    a_r10_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_req && !mst_rsp) |=> (mst_req && $stable(mst_cmd) && $stable(mst_taddr) &&
                                   $stable(mst_proto) && $stable(mst_rd)));

    a_r6_blk_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && (host_addr == OFS_BLK)) |=>
            (blk_idx == IDX_W'($past(blk_idx) + 1'b1)));

endmodule

bind smb_host_regs smb_host_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .mst_req    (mst_req),
    .mst_rsp    (mst_rsp),
    .mst_nack   (mst_nack),
    .mst_proto  (mst_proto),
    .mst_rd     (mst_rd),
    .mst_taddr  (mst_taddr),
    .mst_cmd    (mst_cmd),
    .sts_done   (sts_done),
    .sts_err    (sts_err),
    .blk_idx    (blk_idx)
);

// File: tb/sim_smb_host_regs.sv
`timescale 1ns/1ps
module sim_smb_host_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       mst_req, mst_rd;
    logic [2:0] mst_proto;
    logic [6:0] mst_taddr;
    logic [7:0] mst_cmd, mst_d0, mst_d1, mst_buf_rdata;
    logic [4:0] mst_buf_idx = '0;
    logic       mst_buf_we = 1'b0;
    logic [7:0] mst_buf_wdata = '0;
    logic       mst_rsp = 1'b0, mst_nack = 1'b0;
    logic [7:0] mst_rsp_d0 = '0, mst_rsp_d1 = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    smb_host_regs u0 (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mst_req(mst_req), .mst_proto(mst_proto), .mst_rd(mst_rd),
        .mst_taddr(mst_taddr), .mst_cmd(mst_cmd), .mst_d0(mst_d0), .mst_d1(mst_d1),
        .mst_buf_idx(mst_buf_idx), .mst_buf_rdata(mst_buf_rdata),
        .mst_buf_we(mst_buf_we), .mst_buf_wdata(mst_buf_wdata),
        .mst_rsp(mst_rsp), .mst_nack(mst_nack),
        .mst_rsp_d0(mst_rsp_d0), .mst_rsp_d1(mst_rsp_d1)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, {24'b0, v}, {24'b0, exp});
    endtask

    task automatic respond(input logic nack, input logic [7:0] r0, input logic [7:0] r1);
        @(negedge clk);
        mst_rsp = 1'b1; mst_nack = nack; mst_rsp_d0 = r0; mst_rsp_d1 = r1;
        @(negedge clk);
        mst_rsp = 1'b0; mst_nack = 1'b0;
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) rd_chk("R1 reset register", 3'(a), 8'h00);
        chk("R1 no request after reset", {31'b0, mst_req}, 32'd0);
    endtask

    task automatic t_ctrl_mask();
        wr(3'd2, 8'hBF);
        rd_chk("R2 control low five bits", 3'd2, 8'h1F);
        chk("R2 no start without bit 6", {31'b0, mst_req}, 32'd0);
    endtask

    task automatic t_quick();
        wr(3'd4, 8'hA4);
        wr(3'd5, 8'h11);
        wr(3'd2, 8'h40);
        chk("R2 request after start", {31'b0, mst_req}, 32'd1);
        chk("R2 proto quick", {29'b0, mst_proto}, 32'd0);
        chk("R2 target address", {25'b0, mst_taddr}, 32'h52);
        chk("R2 direction write", {31'b0, mst_rd}, 32'd0);
        rd_chk("R2 busy in status", 3'd0, 8'h01);
        respond(1'b0, 8'hEE, 8'hEE);
        rd_chk("R4 done after ack", 3'd0, 8'h02);
        rd_chk("R5 quick leaves data0", 3'd5, 8'h11);
        wr(3'd0, 8'h06);
    endtask

    task automatic t_byte_read();
        wr(3'd6, 8'h66);
        wr(3'd4, 8'h31);
        wr(3'd2, 8'h44);
        chk("R2 proto byte", {29'b0, mst_proto}, 32'd1);
        chk("R2 direction read", {31'b0, mst_rd}, 32'd1);
        respond(1'b0, 8'h5A, 8'h99);
        rd_chk("R5 byte read data0", 3'd5, 8'h5A);
        rd_chk("R5 byte read keeps data1", 3'd6, 8'h66);
        wr(3'd0, 8'h06);
    endtask

    task automatic t_word_read();
        wr(3'd3, 8'h9C);
        wr(3'd2, 8'h4C);
        chk("R2 command to master", {24'b0, mst_cmd}, 32'h9C);
        respond(1'b0, 8'h34, 8'h12);
        rd_chk("R5 word low byte", 3'd5, 8'h34);
        rd_chk("R5 word high byte", 3'd6, 8'h12);
        wr(3'd0, 8'h06);
    endtask

    task automatic t_nack();
        wr(3'd2, 8'h48);
        respond(1'b1, 8'h77, 8'h77);
        rd_chk("R4 nack sets error not done", 3'd0, 8'h04);
        rd_chk("R4 nack leaves data0", 3'd5, 8'h34);
        wr(3'd0, 8'h06);
    endtask

    task automatic t_bad_proto_w1c();
        wr(3'd2, 8'h50);
        chk("R3 code 4 no request", {31'b0, mst_req}, 32'd0);
        rd_chk("R3 code 4 error", 3'd0, 8'h04);
        wr(3'd0, 8'h06);
        wr(3'd2, 8'h5C);
        chk("R3 code 7 no request", {31'b0, mst_req}, 32'd0);
        wr(3'd2, 8'h40);
        respond(1'b0, 8'h00, 8'h00);
        rd_chk("R9 done and error both set", 3'd0, 8'h06);
        wr(3'd0, 8'h00);
        rd_chk("R9 zero write clears nothing", 3'd0, 8'h06);
        wr(3'd0, 8'h02);
        rd_chk("R9 clear done only", 3'd0, 8'h04);
        wr(3'd0, 8'h04);
        rd_chk("R9 clear error", 3'd0, 8'h00);
    endtask

    task automatic t_busy();
        wr(3'd4, 8'h20);
        wr(3'd3, 8'h41);
        wr(3'd5, 8'h01);
        wr(3'd6, 8'h02);
        wr(3'd2, 8'h4C);
        wr(3'd3, 8'hEE);
        wr(3'd2, 8'h40);
        wr(3'd5, 8'hAA);
        wr(3'd0, 8'h07);
        rd_chk("R9 busy not writable", 3'd0, 8'h01);
        chk("R10 command held", {24'b0, mst_cmd}, 32'h41);
        chk("R10 proto held", {29'b0, mst_proto}, 32'd3);
        respond(1'b0, 8'hFF, 8'hFF);
        rd_chk("R10 command ignored while busy", 3'd3, 8'h41);
        rd_chk("R10 control ignored while busy", 3'd2, 8'h0C);
        rd_chk("R5 word write keeps data0", 3'd5, 8'h01);
        rd_chk("R5 word write keeps data1", 3'd6, 8'h02);
        wr(3'd0, 8'h06);
    endtask

    task automatic t_blk_wrap();
        for (int i = 0; i < 32; i++) wr(3'd7, 8'(i * 7 + 3));
        for (int i = 0; i < 33; i++) begin
            logic [7:0] v;
            rd(3'd7, v);
            chk("R6 block port sequence and wrap", {24'b0, v}, {24'b0, 8'((i % 32) * 7 + 3)});
        end
    endtask

    task automatic t_blk_write();
        for (int i = 0; i < 4; i++) wr(3'd7, 8'(8'hC0 + i));
        wr(3'd5, 8'd5);
        wr(3'd4, 8'h50);
        wr(3'd2, 8'h54);
        chk("R2 proto block", {29'b0, mst_proto}, 32'd5);
        chk("R5 block count to master", {24'b0, mst_d0}, 32'd5);
        for (int i = 0; i < 5; i++) begin
            mst_buf_idx = 5'(i);
            #1;
            chk("R8 master reads buffer", {24'b0, mst_buf_rdata},
                {24'b0, (i == 0) ? 8'd3 : 8'(8'hC0 + i - 1)});
        end
        respond(1'b0, 8'h00, 8'h00);
        rd_chk("R7 index zero after start", 3'd7, 8'd3);
        wr(3'd0, 8'h06);
    endtask

    task automatic t_blk_read();
        wr(3'd4, 8'h51);
        wr(3'd2, 8'h54);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            mst_buf_we = 1'b1; mst_buf_idx = 5'(i); mst_buf_wdata = 8'(8'h70 + i);
        end
        @(negedge clk);
        mst_buf_we = 1'b0;
        respond(1'b0, 8'd6, 8'h00);
        rd_chk("R5 block read count", 3'd5, 8'd6);
        for (int i = 0; i < 6; i++) rd_chk("R8 block read payload", 3'd7, 8'(8'h70 + i));
        @(negedge clk);
        mst_buf_we = 1'b1; mst_buf_idx = 5'd2; mst_buf_wdata = 8'hFF;
        @(negedge clk);
        mst_buf_we = 1'b0;
        #1 chk("R8 idle master write ignored", {24'b0, mst_buf_rdata}, 32'h72);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl_mask();
        t_quick();
        t_byte_read();
        t_word_read();
        t_nack();
        t_bad_proto_w1c();
        t_busy();
        t_blk_wrap();
        t_blk_write();
        t_blk_read();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule